// File: doc/BRIEF.md
# Palette and Direct-Colour Pixel Unpacker

This block sits behind the framebuffer fetch of an LCD controller. It takes 32-bit framebuffer words and turns each one into a run of 24-bit RGB pixels. The number of pixels per word and how they are decoded depend on a 3-bit depth code.

The indexed depths (1, 2, 4 and 8 bits) look each value up in a 256-entry colour table. Software fills that table through a plain write port that packs two 15-bit entries per 32-bit word. The direct depths decode the colour straight from the pixel bits: 16-bit 5551, 16-bit 565, 12-bit 444 held in a 16-bit slot, and 32-bit 888.

A red/blue swap bit and two ordering bits (big-endian bytes, and big-endian pixels within a byte) shape the output. On the base variant, a 2-bit external mux input reinterprets depth code 4 and can force the red/blue swap.

Both stream edges use valid/ready. A word is held until its last pixel is taken. While `out_valid` is high and `out_ready` is low, the pixel holds steady and no new word is taken. `in_ready` is high when the unpacker is empty, or in the cycle in which the last pixel of the held word is handed off, so back-to-back words stream without a bubble. Configuration and the colour table must be held steady while a word is in flight.

Top module: `pxu_unpack_top`

## Requirements
- R1: A table write of word n (`pal_addr`=n) loads entry 2n from `pal_wdata[15:0]` and entry 2n+1 from `pal_wdata[31:16]`, leaving other entries as they were. Reset clears every entry to zero.
- R2: A table entry holds red in bits [4:0], green in [9:5] and blue in [14:10], and bit 15 is ignored. Each 5-bit component leaves as `{c,3'b000}`. `out_pix` is {red[23:16], green[15:8], blue[7:0]}.
- R3: `cfg_depth` codes 0,1,2,3 are indexed 1,2,4,8 bpp, giving 32,16,8,4 pixels per word. Codes 4, 6 and 7 give 2 pixels per word and code 5 gives 1. In the indexed codes the pixel value is the table index.
- R4: With both ordering bits clear, pixel k of a word is bits [k*W+W-1 : k*W], for width W.
- R5: With only `cfg_be_pix` set, for W below 8 the pixels inside each byte are taken from its most significant end, while the bytes go from least significant up.
- R6: With `cfg_be_byte` set, pixel k is slot N-1-k (pixel 0 at the most significant end), whatever `cfg_be_pix` is.
- R7: The direct layouts are as follows. In 5551 (code 4): R[4:0], G[9:5], B[14:10], bit 15 ignored. In 565 (code 6): R[4:0], G[10:5], B[15:11]. In 444 (code 7): R[3:0], G[7:4], B[11:8], bits [15:12] ignored. In 888 (code 5): R[7:0], G[15:8], B[23:16], bits [31:24] ignored. A 5/6/4-bit component widens to 8 bits by repeating its top bits below it.
- R8: `cfg_bgr` exchanges the red and blue output bytes in every depth.
- R9: With `cfg_base_var`=1 and code 4, `fmt_mux` sets the format. A value of 1 gives 5551. A value of 3 gives 565 with red/blue swapped whatever `cfg_bgr` is. A value of 0 or 2 gives 565 following `cfg_bgr`. With `cfg_base_var`=0, `fmt_mux` has no effect.
- R10: After a word is accepted, `out_valid` rises on the next cycle. While `out_ready` is low, `out_valid` and `out_pix` hold, and `in_ready` stays low.
- R11: `in_ready` is high while a word is held only in the cycle in which its last pixel is handed off. A word offered then is taken at once, so output valid runs unbroken across words.
- R12: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 3 | Depth code |
| cfg_bgr | input | 1 | Swap red and blue |
| cfg_be_byte | input | 1 | Big-endian byte order (wins over pixel order) |
| cfg_be_pix | input | 1 | Big-endian pixel order within a byte |
| cfg_base_var | input | 1 | Base variant: code 4 is steered by `fmt_mux` |
| fmt_mux | input | 2 | External 16-bit format select |
| pal_we | input | 1 | Colour table write strobe |
| pal_addr | input | 7 | Colour table word address |
| pal_wdata | input | 32 | Two packed table entries |
| in_valid | input | 1 | Framebuffer word valid |
| in_ready | output | 1 | Unpacker can take a word |
| in_data | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pix | output | 24 | Pixel {R,G,B} |

## Verification
The handoff of a word's last pixel and the acceptance of the next word can fall in the same cycle. The bench provokes this by holding `in_valid` with a second word while the first drains under steady `out_ready`. It judges the result by seeing `in_ready` high on the last-pixel cycle and then `out_valid` held for eight samples in a row, with the fifth sample equal to the first pixel of the second word. A companion stall test holds `out_ready` low and checks that neither the pixel nor the handshake moves.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  localparam int LGW_W = 3;   // width of log2(pixel width) field
  localparam int PIX_W = 24;  // output pixel width

  localparam logic [2:0] DEP_1   = 3'd0;
  localparam logic [2:0] DEP_2   = 3'd1;
  localparam logic [2:0] DEP_4   = 3'd2;
  localparam logic [2:0] DEP_8   = 3'd3;
  localparam logic [2:0] DEP_16  = 3'd4;
  localparam logic [2:0] DEP_32  = 3'd5;
  localparam logic [2:0] DEP_565 = 3'd6;
  localparam logic [2:0] DEP_444 = 3'd7;

  typedef enum logic [2:0] {
    FMT_IDX,
    FMT_5551,
    FMT_565,
    FMT_444,
    FMT_888
  } pxu_fmt_e;

  function automatic logic [7:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] c);
    return {c, c};
  endfunction

endpackage

// File: rtl/pxu_fmt_decode.sv
module pxu_fmt_decode
  import pxu_pkg::*;
(
  input  logic [2:0]       depth,
  input  logic             bgr,
  input  logic             base_var,
  input  logic [1:0]       mux,
  output logic [LGW_W-1:0] lg_w,
  output pxu_fmt_e         fmt,
  output logic             swap
);

  always_comb begin
    swap = bgr;
    fmt  = FMT_IDX;
    lg_w = LGW_W'(4);
    unique case (depth)
      DEP_1, DEP_2, DEP_4, DEP_8: begin
        fmt  = FMT_IDX;
        lg_w = LGW_W'(depth);
      end
      DEP_16: begin
        if (base_var) begin
          unique case (mux)
            2'd1:    fmt = FMT_5551;
            2'd3: begin
              fmt  = FMT_565;
              swap = 1'b1;
            end
            default: fmt = FMT_565;
          endcase
        end else begin
          fmt = FMT_5551;
        end
      end
      DEP_32: begin
        fmt  = FMT_888;
        lg_w = LGW_W'(5);
      end
      DEP_565: fmt = FMT_565;
      DEP_444: fmt = FMT_444;
      default: fmt = FMT_IDX;
    endcase
  end

endmodule

// File: rtl/pxu_palette.sv
module pxu_palette #(
  parameter int PAL_WORDS = 128,
  parameter int WORD_W    = 32,
  localparam int WA       = $clog2(PAL_WORDS),
  localparam int EA       = WA + 1,
  localparam int HALF     = WORD_W / 2,
  localparam int ENT_W    = HALF - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WA-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [EA-1:0]     raddr,
  output logic [ENT_W-1:0]  rentry
);

  logic [ENT_W-1:0] lo_v [PAL_WORDS];
  logic [ENT_W-1:0] hi_v [PAL_WORDS];

  // intensity bits of both halves are dropped on purpose
  logic ibit_unused;
  assign ibit_unused = ^{wdata[WORD_W-1], wdata[HALF-1]};

  for (genvar n = 0; n < PAL_WORDS; n++) begin : g_word
    logic [ENT_W-1:0] lo_q;
    logic [ENT_W-1:0] hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (we && (waddr == WA'(n))) begin
        lo_q <= wdata[ENT_W-1:0];
        hi_q <= wdata[HALF+ENT_W-1:HALF];
      end
    end
    assign lo_v[n] = lo_q;
    assign hi_v[n] = hi_q;
  end

  assign rentry = raddr[0] ? hi_v[raddr[EA-1:1]] : lo_v[raddr[EA-1:1]];

endmodule

// File: rtl/pxu_slicer.sv
module pxu_slicer
  import pxu_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RAW_W   = 24,
  localparam int CNT_W  = $clog2(WORD_W),
  localparam int LG_WORD = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LGW_W-1:0]  lg_w,
  input  logic              be_byte,
  input  logic              be_pix,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RAW_W-1:0]  raw_px
);

  logic              full_q;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  idx_q;

  logic [CNT_W:0]    npix;
  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  flip;
  logic [CNT_W-1:0]  slot;
  logic [CNT_W-1:0]  shamt;
  logic [WORD_W-1:0] wmask;
  logic              last;

  assign npix     = (CNT_W+1)'(WORD_W) >> lg_w;
  assign last_idx = CNT_W'(npix - 1'b1);
  assign last     = (idx_q == last_idx);

  // slot order: byte order reverses the whole word, pixel order only inside a byte
  always_comb begin
    if (be_byte)                           flip = last_idx;
    else if (be_pix && (lg_w < LGW_W'(3))) flip = CNT_W'((8 >> lg_w) - 1);
    else                                   flip = '0;
  end

  assign slot  = idx_q ^ flip;
  assign shamt = slot << lg_w;
  assign wmask = (lg_w >= LGW_W'(LG_WORD)) ? '1
               : ((WORD_W'(1) << (WORD_W'(1) << lg_w)) - WORD_W'(1));

  assign raw_px    = RAW_W'((word_q >> shamt) & wmask);
  assign out_valid = full_q;
  assign in_ready  = !full_q || (out_ready && last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
      idx_q  <= '0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      word_q <= in_data;
      idx_q  <= '0;
    end else if (full_q && out_ready) begin
      if (last) full_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/pxu_color.sv
module pxu_color
  import pxu_pkg::*;
#(
  parameter int RAW_W = 24,
  parameter int IDX_W = 8,
  parameter int ENT_W = 15
) (
  input  pxu_fmt_e         fmt,
  input  logic             swap,
  input  logic [RAW_W-1:0] raw_px,
  input  logic [ENT_W-1:0] pal_entry,
  output logic [IDX_W-1:0] pal_idx,
  output logic [PIX_W-1:0] pix
);

  logic [7:0] r, g, b;

  assign pal_idx = raw_px[IDX_W-1:0];

  always_comb begin
    unique case (fmt)
      FMT_IDX: begin
        r = {pal_entry[4:0],   3'b000};
        g = {pal_entry[9:5],   3'b000};
        b = {pal_entry[14:10], 3'b000};
      end
      FMT_5551: begin
        r = widen5(raw_px[4:0]);
        g = widen5(raw_px[9:5]);
        b = widen5(raw_px[14:10]);
      end
      FMT_565: begin
        r = widen5(raw_px[4:0]);
        g = widen6(raw_px[10:5]);
        b = widen5(raw_px[15:11]);
      end
      FMT_444: begin
        r = widen4(raw_px[3:0]);
        g = widen4(raw_px[7:4]);
        b = widen4(raw_px[11:8]);
      end
      default: begin
        r = raw_px[7:0];
        g = raw_px[15:8];
        b = raw_px[23:16];
      end
    endcase
    pix = swap ? {b, g, r} : {r, g, b};
  end

endmodule

// File: rtl/pxu_unpack_top.sv
module pxu_unpack_top
  import pxu_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int PAL_WORDS = 128,
  localparam int WA       = $clog2(PAL_WORDS),
  localparam int EA       = WA + 1,
  localparam int ENT_W    = WORD_W / 2 - 1,
  localparam int RAW_W    = PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_bgr,
  input  logic              cfg_be_byte,
  input  logic              cfg_be_pix,
  input  logic              cfg_base_var,
  input  logic [1:0]        fmt_mux,
  input  logic              pal_we,
  input  logic [WA-1:0]     pal_addr,
  input  logic [WORD_W-1:0] pal_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix
);

  logic [LGW_W-1:0] lg_w;
  pxu_fmt_e         fmt;
  logic             swap;
  logic [RAW_W-1:0] raw_px;
  logic [EA-1:0]    pal_idx;
  logic [ENT_W-1:0] pal_entry;

  pxu_fmt_decode u_dec (
    .depth    (cfg_depth),
    .bgr      (cfg_bgr),
    .base_var (cfg_base_var),
    .mux      (fmt_mux),
    .lg_w     (lg_w),
    .fmt      (fmt),
    .swap     (swap)
  );

  pxu_slicer #(.WORD_W(WORD_W), .RAW_W(RAW_W)) u_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .lg_w      (lg_w),
    .be_byte   (cfg_be_byte),
    .be_pix    (cfg_be_pix),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .raw_px    (raw_px)
  );

  pxu_palette #(.PAL_WORDS(PAL_WORDS), .WORD_W(WORD_W)) u_pal (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (pal_we),
    .waddr  (pal_addr),
    .wdata  (pal_wdata),
    .raddr  (pal_idx),
    .rentry (pal_entry)
  );

  pxu_color #(.RAW_W(RAW_W), .IDX_W(EA), .ENT_W(ENT_W)) u_col (
    .fmt       (fmt),
    .swap      (swap),
    .raw_px    (raw_px),
    .pal_entry (pal_entry),
    .pal_idx   (pal_idx),
    .pix       (out_pix)
  );

endmodule

// File: rtl/pxu_unpack_chk.sv
module pxu_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cfg_depth,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_pix
);

  logic [5:0] n_exp;
  logic [5:0] sent_q;
  logic       take_in;
  logic       take_out;

  assign take_in  = in_valid && in_ready;
  assign take_out = out_valid && out_ready;

  always_comb begin
    case (cfg_depth)
      3'd0:    n_exp = 6'd32;
      3'd1:    n_exp = 6'd16;
      3'd2:    n_exp = 6'd8;
      3'd3:    n_exp = 6'd4;
      3'd5:    n_exp = 6'd1;
      default: n_exp = 6'd2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sent_q <= '0;
    else if (take_in)  sent_q <= '0;
    else if (take_out) sent_q <= sent_q + 1'b1;
  end

  p_idle_after_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  p_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_in |=> out_valid);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  p_refill_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_ready) |-> (out_ready && (sent_q == n_exp - 6'd1)));

  p_word_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_out && (sent_q == n_exp - 6'd1) && !take_in) |=> !out_valid);

endmodule

bind pxu_unpack_top pxu_unpack_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_depth (cfg_depth),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix)
);

// File: tb/pxu_unpack_tb.sv
module pxu_unpack_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_depth = 3'd3;
  logic        cfg_bgr = 1'b0, cfg_be_byte = 1'b0, cfg_be_pix = 1'b0, cfg_base_var = 1'b0;
  logic [1:0]  fmt_mux = 2'd0;
  logic        pal_we = 1'b0;
  logic [6:0]  pal_addr = '0;
  logic [31:0] pal_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_pix;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [23:0] pix_buf [64];

  always #5 clk = ~clk;

  pxu_unpack_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
    .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix), .cfg_base_var(cfg_base_var),
    .fmt_mux(fmt_mux), .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  typedef struct packed {
    logic [2:0]  depth;
    logic        bgr;
    logic        bb;
    logic        bp;
    logic        base;
    logic [1:0]  mux;
    logic [31:0] word;
    logic [5:0]  p;
    logic [5:0]  n;
    logic [23:0] expv;
  } vec_t;

  // depth bgr bb bp base mux word p n expected
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{3'd3,1'b0,1'b0,1'b0,1'b0,2'd0,32'h03020100,6'd0, 6'd4, 24'h081018}, // R2 R4 entry0
    '{3'd3,1'b0,1'b0,1'b0,1'b0,2'd0,32'h03020100,6'd3, 6'd4, 24'h2850A0}, // R4 entry3
    '{3'd3,1'b0,1'b1,1'b0,1'b0,2'd0,32'h03020100,6'd0, 6'd4, 24'h2850A0}, // R6
    '{3'd3,1'b1,1'b0,1'b0,1'b0,2'd0,32'h00000001,6'd0, 6'd4, 24'h8000F8}, // R8 indexed
    '{3'd0,1'b0,1'b0,1'b0,1'b0,2'd0,32'h00000002,6'd1, 6'd32,24'hF80080}, // R3 R2 bit15 ignored
    '{3'd0,1'b0,1'b0,1'b1,1'b0,2'd0,32'h00000002,6'd6, 6'd32,24'hF80080}, // R5
    '{3'd0,1'b0,1'b1,1'b1,1'b0,2'd0,32'h00000002,6'd30,6'd32,24'hF80080}, // R6 priority
    '{3'd1,1'b0,1'b0,1'b0,1'b0,2'd0,32'h000000E4,6'd2, 6'd16,24'h00F800}, // R3 R4 2bpp
    '{3'd2,1'b0,1'b0,1'b1,1'b0,2'd0,32'h00000023,6'd0, 6'd8, 24'h00F800}, // R5 4bpp
    '{3'd3,1'b0,1'b0,1'b0,1'b0,2'd0,32'h000000FF,6'd0, 6'd4, 24'h102030}, // R1 entry255
    '{3'd5,1'b0,1'b0,1'b0,1'b0,2'd0,32'hAA332211,6'd0, 6'd1, 24'h112233}, // R7 888
    '{3'd5,1'b1,1'b0,1'b0,1'b0,2'd0,32'hAA332211,6'd0, 6'd1, 24'h332211}, // R8 888
    '{3'd4,1'b0,1'b0,1'b0,1'b0,2'd3,32'h0000FC30,6'd0, 6'd2, 24'h8408FF}, // R7 5551 R9 mux ignored
    '{3'd6,1'b0,1'b0,1'b0,1'b0,2'd0,32'h87E10000,6'd1, 6'd2, 24'h08FF84}, // R7 565
    '{3'd7,1'b0,1'b0,1'b0,1'b0,2'd0,32'h0000FFA1,6'd0, 6'd2, 24'h11AAFF}, // R7 444
    '{3'd4,1'b0,1'b0,1'b0,1'b1,2'd1,32'h0000FC30,6'd0, 6'd2, 24'h8408FF}, // R9 mux1
    '{3'd4,1'b0,1'b0,1'b0,1'b1,2'd0,32'h000087E1,6'd0, 6'd2, 24'h08FF84}, // R9 mux0
    '{3'd4,1'b1,1'b0,1'b0,1'b1,2'd2,32'h000087E1,6'd0, 6'd2, 24'h84FF08}, // R9 mux2 bgr
    '{3'd4,1'b0,1'b0,1'b0,1'b1,2'd3,32'h000087E1,6'd0, 6'd2, 24'h84FF08}, // R9 mux3 forced
    '{3'd6,1'b0,1'b1,1'b0,1'b0,2'd0,32'h87E1FC30,6'd0, 6'd2, 24'h08FF84}  // R6 16-bit
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic pal_wr(input logic [6:0] n, input logic [31:0] d);
    @(negedge clk);
    pal_we = 1'b1; pal_addr = n; pal_wdata = d;
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  task automatic send_collect(input logic [31:0] w, output int cnt);
    @(negedge clk);
    in_data = w; in_valid = 1'b1; out_ready = 1'b1; cnt = 0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (out_valid && cnt < 40) begin
      pix_buf[cnt] = out_pix;
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input vec_t v);
    @(negedge clk);
    cfg_depth = v.depth; cfg_bgr = v.bgr; cfg_be_byte = v.bb; cfg_be_pix = v.bp;
    cfg_base_var = v.base; fmt_mux = v.mux;
  endtask

  initial begin
    int cnt;
    vec_t d8;
    d8 = VECS[0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R12 out_valid after reset", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R12 in_ready after reset", 32'(in_ready), 32'h1);

    // unwritten entry 128 is zero after reset
    set_cfg(d8);
    send_collect(32'h00000080, cnt);
    check(pix_buf[0] == 24'h0, "R1 reset table entry", 32'(pix_buf[0]), 32'h0);

    pal_wr(7'd0,   32'hC01F0C41);
    pal_wr(7'd1,   32'h514503E0);
    pal_wr(7'd127, 32'h18820000);

    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i]);
      send_collect(VECS[i].word, cnt);
      check(cnt == int'(VECS[i].n), $sformatf("R3 vector %0d pixel count", i), 32'(cnt), 32'(VECS[i].n));
      check(pix_buf[VECS[i].p] == VECS[i].expv, $sformatf("vector %0d pixel (R2/R4-R9)", i),
            32'(pix_buf[VECS[i].p]), 32'(VECS[i].expv));
    end

    // R1: neighbouring word untouched
    set_cfg(d8);
    send_collect(32'h00000004, cnt);
    check(pix_buf[0] == 24'h0, "R1 entry4 untouched", 32'(pix_buf[0]), 32'h0);

    // R10: stall holds pixel and blocks input
    @(negedge clk);
    in_data = 32'h03020100; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(out_valid == 1'b1, "R10 valid held in stall", 32'(out_valid), 32'h1);
      check(out_pix == 24'h081018, "R10 pixel held in stall", 32'(out_pix), 32'h081018);
      check(in_ready == 1'b0, "R10 in_ready low in stall", 32'(in_ready), 32'h0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R10 drained after release", 32'(out_valid), 32'h0);

    // R11: back-to-back words, no bubble
    @(negedge clk);
    in_data = 32'h03020100; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_data = 32'h00000102;
    for (int k = 0; k < 8; k++) begin
      pix_buf[k] = out_pix;
      check(out_valid == 1'b1, $sformatf("R11 valid unbroken at %0d", k), 32'(out_valid), 32'h1);
      if (k == 3) check(in_ready == 1'b1, "R11 in_ready on last pixel", 32'(in_ready), 32'h1);
      if (k == 1) check(in_ready == 1'b0, "R11 in_ready low mid-word", 32'(in_ready), 32'h0);
      if (k == 4) in_valid = 1'b0;
      @(negedge clk);
    end
    check(pix_buf[4] == 24'h00F800, "R11 first pixel of second word", 32'(pix_buf[4]), 32'h00F800);
    check(out_valid == 1'b0, "R11 empty after two words", 32'(out_valid), 32'h0);

    // R1: rewrite word 1 changes both halves
    pal_wr(7'd1, 32'h00007FFF);
    send_collect(32'h00000302, cnt);
    check(pix_buf[0] == 24'hF8F8F8, "R1 low half rewritten", 32'(pix_buf[0]), 32'hF8F8F8);
    check(pix_buf[1] == 24'h000000, "R1 high half rewritten", 32'(pix_buf[1]), 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule